// File: doc/BRIEF.md
# Twin-Port Synchronous RAM

This block is a small shared memory with two fully independent access ports, each running on its own clock. Either port can read or write any word in any cycle, and both ports may touch the same word at the same time. Every port samples its select lines, its read/write control, its address and its write data on the rising edge of its own clock. A write stores the sampled data at the sampled address. A read returns the word stored at the sampled address.

Each port has a static latency select. In direct mode the word read at an edge appears at the outputs in the cycle that follows that edge. In registered mode an extra output register delays it by one more edge. A port is active only while its active-low select is low and its active-high select is high. An asynchronous output enable gates the result, and a valid flag marks the cycles in which the port drives real read data. While the flag is low the data bus reads all zeros.

Top module: `twin_port_sram`

## Requirements
- R1: A port is selected at an edge only when its active-low select is 0 and its active-high select is 1. At an edge with any other select combination the port neither writes nor reads, and in direct mode its valid flag is 0 in the following cycle.
- R2: At a selected edge, read/write = 0 stores the write data at the address, and read/write = 1 reads the word at the address.
- R3: While the output enable (active low) is 1, the valid flag is 0 at once, independent of the clock. The read in progress is not disturbed, and a later read of the same word returns it unchanged.
- R4: In direct mode (latency select = 0), a read sampled at edge k presents its word with the valid flag at 1 during the cycle after edge k.
- R5: In registered mode (latency select = 1), a read sampled at edge k presents its word with the valid flag at 1 during the cycle after edge k+1.
- R6: The output state follows the controls registered at the earlier edge. A write cycle or a deselected cycle at edge k gives valid = 0 after edge k in direct mode and after edge k+1 in registered mode.
- R7: Both ports can access any word in the same cycle, including the same word. A word written by one port at an edge is returned by a read of the other port at any later edge.
- R8: The read data output is all zeros in every cycle in which the valid flag is 0.
- R9: While a port's reset (active low) is asserted and after its release, before any read, the valid flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_clk | input | 1 | Port A clock, rising edge |
| a_rst_n | input | 1 | Port A reset, active low |
| a_pipe | input | 1 | Port A latency select, 0 = direct, 1 = registered; static |
| a_en_n | input | 1 | Port A select, active low |
| a_en | input | 1 | Port A select, active high |
| a_wr_n | input | 1 | Port A read/write: 0 = write, 1 = read |
| a_oe_n | input | 1 | Port A asynchronous output enable, active low |
| a_addr | input | AW | Port A word address |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A read data, zero when not valid |
| a_rvalid | output | 1 | Port A read data valid |
| b_clk | input | 1 | Port B clock, rising edge |
| b_rst_n | input | 1 | Port B reset, active low |
| b_pipe | input | 1 | Port B latency select, 0 = direct, 1 = registered; static |
| b_en_n | input | 1 | Port B select, active low |
| b_en | input | 1 | Port B select, active high |
| b_wr_n | input | 1 | Port B read/write: 0 = write, 1 = read |
| b_oe_n | input | 1 | Port B asynchronous output enable, active low |
| b_addr | input | AW | Port B word address |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B read data, zero when not valid |
| b_rvalid | output | 1 | Port B read data valid |

## Verification
The assertions watch the valid-flag timing on every edge of each port: the flag drops after a deselected edge in direct mode, it stays low two edges after a write or a deselect in registered mode, it matches the output enable after a read in either mode, it is forced low by the output enable, and the data bus is zero whenever the flag is low. The values of the words returned can only be shown by the bench's scenarios. These cover writes by one port read back by the other, concurrent reads of the same word, blocked writes under each deselect combination, and reads whose result lands while the output enable is high.

// File: rtl/twin_port_sram_pkg.sv
package twin_port_sram_pkg;

  // A port takes part in an edge only with low-side select low and high-side select high.
  function automatic logic port_selected(input logic sel_lo_n, input logic sel_hi);
    return (!sel_lo_n) && sel_hi;
  endfunction

  // Two halves of a stored word combine by XOR into the visible value.
  function automatic logic [63:0] merge_halves(input logic [63:0] h0, input logic [63:0] h1);
    return h0 ^ h1;
  endfunction

  // Number of read taps on each storage half: reader A, reader B, write encoder of the peer.
  localparam int unsigned TAPS = 3;
  localparam int unsigned TAP_WENC = 2;

endpackage

// File: rtl/tps_port_ctl.sv
module tps_port_ctl #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_n,
  input  logic          en,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  output logic          wr_go,
  output logic          rd_q,
  output logic [AW-1:0] addr_q
);
  import twin_port_sram_pkg::*;

  logic sel_now;
  assign sel_now = port_selected(en_n, en);
  // write event acts on the storage at this edge
  assign wr_go   = sel_now && !wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      rd_q   <= sel_now && wr_n;
      addr_q <= addr;
    end
  end
endmodule

// File: rtl/tps_xor_half.sv
module tps_xor_half #(
  parameter int unsigned AW   = 8,
  parameter int unsigned DW   = 8,
  parameter int unsigned NRD  = 3
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [DW-1:0]           wenc,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][DW-1:0]  rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wenc;
  end

  for (genvar t = 0; t < NRD; t++) begin : g_tap
    assign rdata[t] = cells[raddr[t]];
  end
endmodule

// File: rtl/tps_port_out.sv
module tps_port_out #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pipe,
  input  logic          oe_n,
  input  logic          rd_q,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic          pv_q;
  logic [DW-1:0] pd_q;
  logic          live;
  logic [DW-1:0] pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q <= 1'b0;
      pd_q <= '0;
    end else begin
      pv_q <= rd_q;
      if (rd_q) pd_q <= word;
    end
  end

  assign live   = pipe ? pv_q : rd_q;
  assign pick   = pipe ? pd_q : word;
  assign rvalid = live && !oe_n;
  assign rdata  = rvalid ? pick : '0;
endmodule

// File: rtl/twin_port_sram.sv
module twin_port_sram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          a_clk,
  input  logic          a_rst_n,
  input  logic          a_pipe,
  input  logic          a_en_n,
  input  logic          a_en,
  input  logic          a_wr_n,
  input  logic          a_oe_n,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_rvalid,
  input  logic          b_clk,
  input  logic          b_rst_n,
  input  logic          b_pipe,
  input  logic          b_en_n,
  input  logic          b_en,
  input  logic          b_wr_n,
  input  logic          b_oe_n,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_rvalid
);
  import twin_port_sram_pkg::*;

  localparam int unsigned NP = 2;

  logic [NP-1:0]                 clk_v, rst_v, pipe_v, en_n_v, en_v, wr_n_v, oe_v;
  logic [NP-1:0][AW-1:0]         addr_v, addr_q;
  logic [NP-1:0][DW-1:0]         wdata_v, word_v, rdata_v;
  logic [NP-1:0]                 wr_go, rd_q, rvalid_v;
  logic [NP-1:0][TAPS-1:0][AW-1:0] tap_addr;
  logic [NP-1:0][TAPS-1:0][DW-1:0] tap_data;
  logic [NP-1:0][DW-1:0]         wenc;

  assign clk_v   = {b_clk,   a_clk};
  assign rst_v   = {b_rst_n, a_rst_n};
  assign pipe_v  = {b_pipe,  a_pipe};
  assign en_n_v  = {b_en_n,  a_en_n};
  assign en_v    = {b_en,    a_en};
  assign wr_n_v  = {b_wr_n,  a_wr_n};
  assign oe_v    = {b_oe_n,  a_oe_n};
  assign addr_v  = {b_addr,  a_addr};
  assign wdata_v = {b_wdata, a_wdata};

  for (genvar p = 0; p < NP; p++) begin : g_port
    tps_port_ctl #(.AW(AW)) u_ctl (
      .clk    (clk_v[p]),
      .rst_n  (rst_v[p]),
      .en_n   (en_n_v[p]),
      .en     (en_v[p]),
      .wr_n   (wr_n_v[p]),
      .addr   (addr_v[p]),
      .wr_go  (wr_go[p]),
      .rd_q   (rd_q[p]),
      .addr_q (addr_q[p])
    );

    // storage half p taps: both readers, plus the peer's write address
    assign tap_addr[p][0]        = addr_q[0];
    assign tap_addr[p][1]        = addr_q[1];
    assign tap_addr[p][TAP_WENC] = addr_v[NP-1-p];

    // the half a port owns stores its data XOR the other half's current content
    assign wenc[p] = DW'(merge_halves(64'(wdata_v[p]), 64'(tap_data[NP-1-p][TAP_WENC])));

    tps_xor_half #(.AW(AW), .DW(DW), .NRD(TAPS)) u_half (
      .clk   (clk_v[p]),
      .we    (wr_go[p]),
      .waddr (addr_v[p]),
      .wenc  (wenc[p]),
      .raddr (tap_addr[p]),
      .rdata (tap_data[p])
    );

    assign word_v[p] = DW'(merge_halves(64'(tap_data[0][p]), 64'(tap_data[1][p])));

    tps_port_out #(.DW(DW)) u_out (
      .clk    (clk_v[p]),
      .rst_n  (rst_v[p]),
      .pipe   (pipe_v[p]),
      .oe_n   (oe_v[p]),
      .rd_q   (rd_q[p]),
      .word   (word_v[p]),
      .rdata  (rdata_v[p]),
      .rvalid (rvalid_v[p])
    );
  end

  assign a_rdata  = rdata_v[0];
  assign a_rvalid = rvalid_v[0];
  assign b_rdata  = rdata_v[1];
  assign b_rvalid = rvalid_v[1];
endmodule

// File: rtl/twin_port_sram_chk.sv
module twin_port_sram_chk #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input logic          a_clk,
  input logic          a_rst_n,
  input logic          a_pipe,
  input logic          a_en_n,
  input logic          a_en,
  input logic          a_wr_n,
  input logic          a_oe_n,
  input logic [AW-1:0] a_addr,
  input logic [DW-1:0] a_wdata,
  input logic [DW-1:0] a_rdata,
  input logic          a_rvalid,
  input logic          b_clk,
  input logic          b_rst_n,
  input logic          b_pipe,
  input logic          b_en_n,
  input logic          b_en,
  input logic          b_wr_n,
  input logic          b_oe_n,
  input logic [AW-1:0] b_addr,
  input logic [DW-1:0] b_wdata,
  input logic [DW-1:0] b_rdata,
  input logic          b_rvalid
);
  logic a_sel, b_sel;
  assign a_sel = !a_en_n && a_en;
  assign b_sel = !b_en_n && b_en;

  // R1: direct mode, deselected edge gives no valid output after it
  a_r1_desel_quiet_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    (!a_pipe && !a_sel) |=> !a_rvalid);
  a_r1_desel_quiet_b: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    (!b_pipe && !b_sel) |=> !b_rvalid);

  // R3: output enable high blocks the valid flag
  a_r3_oe_blocks_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    a_oe_n |-> !a_rvalid);
  a_r3_oe_blocks_b: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    b_oe_n |-> !b_rvalid);

  // R8: data bus is zero whenever not valid
  a_r8_idle_zero_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    !a_rvalid |-> (a_rdata == '0));
  a_r8_idle_zero_b: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    !b_rvalid |-> (b_rdata == '0));

  // R4: direct-mode read is valid one edge later unless the output enable is high
  a_r4_flow_read_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    (!a_pipe && a_sel && a_wr_n) |=> (a_rvalid == !a_oe_n));
  a_r4_flow_read_b: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    (!b_pipe && b_sel && b_wr_n) |=> (b_rvalid == !b_oe_n));

  // R5: registered-mode read is valid two edges later unless the output enable is high
  a_r5_pipe_read_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    (a_pipe && a_sel && a_wr_n) |=> ##1 (a_rvalid == !a_oe_n));
  a_r5_pipe_read_b: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    (b_pipe && b_sel && b_wr_n) |=> ##1 (b_rvalid == !b_oe_n));

  // R6: registered mode, write or deselect leaves a gap two edges later
  a_r6_pipe_gap_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    (a_pipe && !(a_sel && a_wr_n)) |=> ##1 !a_rvalid);
  a_r6_pipe_gap_b: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    (b_pipe && !(b_sel && b_wr_n)) |=> ##1 !b_rvalid);
endmodule

bind twin_port_sram twin_port_sram_chk #(.AW(AW), .DW(DW)) u_chk (
  .a_clk(a_clk), .a_rst_n(a_rst_n), .a_pipe(a_pipe), .a_en_n(a_en_n), .a_en(a_en),
  .a_wr_n(a_wr_n), .a_oe_n(a_oe_n), .a_addr(a_addr), .a_wdata(a_wdata),
  .a_rdata(a_rdata), .a_rvalid(a_rvalid),
  .b_clk(b_clk), .b_rst_n(b_rst_n), .b_pipe(b_pipe), .b_en_n(b_en_n), .b_en(b_en),
  .b_wr_n(b_wr_n), .b_oe_n(b_oe_n), .b_addr(b_addr), .b_wdata(b_wdata),
  .b_rdata(b_rdata), .b_rvalid(b_rvalid)
);

// File: tb/twin_port_sram_bench.sv
module twin_port_sram_bench;
  // one shared clock of 8 time units (125 MHz at a 1 ns unit) drives both ports

  typedef struct {
    logic       en_n;
    logic       en;
    logic       wr_n;
    logic [7:0] addr;
    logic [7:0] wdata;
    logic       oe_n;
  } cmd_t;

  typedef struct {
    int         due;
    logic       ctl;
    logic [7:0] data;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       a_pipe = 1'b0, b_pipe = 1'b0;
  logic       a_en_n = 1'b1, a_en = 1'b0, a_wr_n = 1'b1, a_oe_n = 1'b0;
  logic       b_en_n = 1'b1, b_en = 1'b0, b_wr_n = 1'b1, b_oe_n = 1'b0;
  logic [7:0] a_addr = '0, a_wdata = '0, b_addr = '0, b_wdata = '0;
  logic [7:0] a_rdata, b_rdata;
  logic       a_rvalid, b_rvalid;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;
  bit   reported = 0;
  exp_t qa[$];
  exp_t qb[$];
  logic [7:0] model [256];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  twin_port_sram u_twin_port_sram (
    .a_clk(clk), .a_rst_n(rst_n), .a_pipe(a_pipe), .a_en_n(a_en_n), .a_en(a_en),
    .a_wr_n(a_wr_n), .a_oe_n(a_oe_n), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_rvalid(a_rvalid),
    .b_clk(clk), .b_rst_n(rst_n), .b_pipe(b_pipe), .b_en_n(b_en_n), .b_en(b_en),
    .b_wr_n(b_wr_n), .b_oe_n(b_oe_n), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_rvalid(b_rvalid)
  );

  function automatic cmd_t c_rd(input logic [7:0] ad, input logic oe = 1'b0);
    cmd_t c; c.en_n = 0; c.en = 1; c.wr_n = 1; c.addr = ad; c.wdata = 8'h00; c.oe_n = oe;
    return c;
  endfunction
  function automatic cmd_t c_wr(input logic [7:0] ad, input logic [7:0] d);
    cmd_t c; c.en_n = 0; c.en = 1; c.wr_n = 0; c.addr = ad; c.wdata = d; c.oe_n = 0;
    return c;
  endfunction
  function automatic cmd_t c_off(input logic lo_n, input logic hi, input logic wn,
                                 input logic [7:0] ad, input logic [7:0] d);
    cmd_t c; c.en_n = lo_n; c.en = hi; c.wr_n = wn; c.addr = ad; c.wdata = d; c.oe_n = 0;
    return c;
  endfunction
  function automatic cmd_t c_idle();
    return c_off(1'b1, 1'b0, 1'b1, 8'h00, 8'h00);
  endfunction

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    end
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // driver: applies one command per port, pushes expectations, updates model
  task automatic step(input cmd_t ca, input cmd_t cb, input string ta, input string tb);
    exp_t ea, eb;
    @(negedge clk);
    a_en_n = ca.en_n; a_en = ca.en; a_wr_n = ca.wr_n; a_addr = ca.addr;
    a_wdata = ca.wdata; a_oe_n = ca.oe_n;
    b_en_n = cb.en_n; b_en = cb.en; b_wr_n = cb.wr_n; b_addr = cb.addr;
    b_wdata = cb.wdata; b_oe_n = cb.oe_n;
    ea.due = cyc + 1 + (a_pipe ? 1 : 0);
    ea.ctl = !ca.en_n && ca.en && ca.wr_n;
    ea.data = model[ca.addr];
    ea.tag = ta;
    eb.due = cyc + 1 + (b_pipe ? 1 : 0);
    eb.ctl = !cb.en_n && cb.en && cb.wr_n;
    eb.data = model[cb.addr];
    eb.tag = tb;
    qa.push_back(ea);
    qb.push_back(eb);
    if (!ca.en_n && ca.en && !ca.wr_n) model[ca.addr] = ca.wdata;
    if (!cb.en_n && cb.en && !cb.wr_n) model[cb.addr] = cb.wdata;
  endtask

  task automatic cmp(input exp_t e, input logic rv, input logic [7:0] rd,
                     input logic oe, input string pn);
    logic ev;
    ev = e.ctl && !oe;
    chk(rv == ev, e.tag, {pn, " rvalid"}, int'(rv), int'(ev));
    if (ev) chk(rd == e.data, e.tag, {pn, " rdata"}, int'(rd), int'(e.data));
    else    chk(rd == 8'h00, "R8", {pn, " rdata while invalid"}, int'(rd), 0);
  endtask

  // monitor: pops expectations when due and compares against the outputs
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (qa.size() > 0 && qa[0].due < cyc) void'(qa.pop_front());
      while (qb.size() > 0 && qb[0].due < cyc) void'(qb.pop_front());
      if (qa.size() > 0 && qa[0].due == cyc) cmp(qa.pop_front(), a_rvalid, a_rdata, a_oe_n, "port A");
      if (qb.size() > 0 && qb[0].due == cyc) cmp(qb.pop_front(), b_rvalid, b_rdata, b_oe_n, "port B");
    end
  end

  task automatic settle();
    for (int i = 0; i < 3; i++) step(c_idle(), c_idle(), "R6", "R6");
  endtask

  task automatic restart(input logic pa, input logic pb);
    @(negedge clk);
    rst_n = 1'b0;
    a_pipe = pa; b_pipe = pb;
    repeat (3) @(negedge clk);
    #2;
    chk(a_rvalid == 1'b0 && b_rvalid == 1'b0, "R9", "valid during reset",
        int'({a_rvalid, b_rvalid}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    qa.delete(); qb.delete();
    #2;
    chk(a_rvalid == 1'b0 && b_rvalid == 1'b0, "R9", "valid after reset release",
        int'({a_rvalid, b_rvalid}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run incomplete, got done=0 expected done=1");
      report();
      $finish;
    end
  end

  initial begin
    logic [7:0] ad;
    // ---------------- direct mode on both ports ----------------
    restart(1'b0, 1'b0);
    // R2 R6: port A writes a spread of words including both ends; B idle (R1)
    for (int i = 0; i < 10; i++) begin
      ad = (i == 8) ? 8'h00 : (i == 9) ? 8'hFF : 8'(i * 37 + 3);
      step(c_wr(ad, 8'(i * 29 + 8'h5A)), c_idle(), "R6", "R1");
    end
    // R7 R4: B reads the words A wrote while A reads them too (same word at once)
    for (int i = 0; i < 10; i++) begin
      ad = (i == 8) ? 8'h00 : (i == 9) ? 8'hFF : 8'(i * 37 + 3);
      step(c_rd(ad), c_rd(ad), "R4", "R7");
    end
    // R2: B writes a block while A reads other words
    for (int i = 0; i < 8; i++) step(c_rd(8'(i * 37 + 3)), c_wr(8'(16 + i), 8'(8'hC3 ^ i)), "R2", "R6");
    // R7: A reads what B wrote
    for (int i = 0; i < 8; i++) step(c_rd(8'(16 + i)), c_idle(), "R7", "R1");
    // R3: output enable high while a result is due, then the same word again
    step(c_rd(8'd16), c_idle(), "R3", "R1");
    step(c_rd(8'd17, 1'b1), c_idle(), "R3", "R1");
    step(c_rd(8'd16), c_idle(), "R3", "R1");
    step(c_rd(8'd17), c_idle(), "R3", "R1");
    // R1: write attempts under each deselect combination, with reads mixed in
    step(c_off(1'b1, 1'b1, 1'b0, 8'd16, 8'hEE), c_off(1'b0, 1'b0, 1'b0, 8'd17, 8'hEE), "R1", "R1");
    step(c_off(1'b1, 1'b0, 1'b0, 8'd18, 8'hEE), c_off(1'b1, 1'b1, 1'b1, 8'd18, 8'h00), "R1", "R1");
    step(c_off(1'b0, 1'b0, 1'b1, 8'd16, 8'h00), c_off(1'b1, 1'b0, 1'b0, 8'd19, 8'hEE), "R1", "R1");
    for (int i = 0; i < 4; i++) step(c_rd(8'(16 + i)), c_rd(8'(19 - i)), "R1", "R1");
    settle();

    // ---------------- registered mode on both ports ----------------
    restart(1'b1, 1'b1);
    for (int i = 0; i < 8; i++) step(c_rd(8'(i * 37 + 3)), c_wr(8'(40 + i), 8'(8'h11 * (i + 1))), "R5", "R6");
    for (int i = 0; i < 8; i++) step(c_rd(8'(40 + i)), c_rd(8'(47 - i)), "R7", "R5");
    // R6: read, write, read, deselect, read on port A
    step(c_rd(8'd40), c_idle(), "R6", "R6");
    step(c_wr(8'd41, 8'h9C), c_idle(), "R6", "R6");
    step(c_rd(8'd41), c_idle(), "R6", "R6");
    step(c_idle(), c_idle(), "R6", "R6");
    step(c_rd(8'd42), c_idle(), "R6", "R6");
    step(c_rd(8'd43), c_idle(), "R6", "R6");
    // R3: output enable high in the cycle the registered result lands
    step(c_rd(8'd44), c_idle(), "R3", "R6");
    step(c_rd(8'd45), c_idle(), "R3", "R6");
    step(c_rd(8'd44, 1'b1), c_idle(), "R3", "R6");
    step(c_rd(8'd45), c_idle(), "R3", "R6");
    step(c_idle(), c_idle(), "R3", "R6");
    settle();

    // ---------------- mixed: A registered, B direct ----------------
    restart(1'b1, 1'b0);
    step(c_wr(8'd200, 8'hA5), c_wr(8'd201, 8'h5A), "R6", "R6");
    step(c_rd(8'd201), c_rd(8'd200), "R7", "R7");
    step(c_rd(8'd200), c_rd(8'd200), "R7", "R7");
    step(c_wr(8'd200, 8'h3C), c_rd(8'd201), "R6", "R4");
    step(c_idle(), c_rd(8'd200), "R6", "R7");
    step(c_rd(8'd200), c_idle(), "R7", "R1");
    settle();

    done = 1;
    report();
    $finish;
  end
endmodule